// File: doc/BRIEF.md
# Packet FIFO with Length Queue

This block buffers whole packets between a 32-bit register bus and a word-wide packet stream. On the transmit side, software writes a packet's data words into a data port. It then writes the packet's byte count to a length register. The count releases the packet to the output stream, where it leaves with start and end markers and the number of valid bytes in its last word. If the count does not match the words supplied, the uncommitted words are discarded and a size error is raised.

On the receive side, words arriving on the input stream are stored, and the byte count of each packet is queued when its last word arrives. Software reads the oldest length first and then drains that many words from the data port. A status register collects error and event flags, which are cleared by writing ones. An enable mask gates them onto a single interrupt line.

The transmit path, the receive path, or both together can be cleared by writing the key value 0xA5 to one of three reset registers. Each clear takes one cycle in a sequencer with the states RS_IDLE and RS_CLEAR. A key write moves RS_IDLE to RS_CLEAR. RS_CLEAR always returns to RS_IDLE and, on that transition, sets the matching reset-done flag. The output stream is driven by an egress machine with the states EG_IDLE and EG_SEND. EG_IDLE moves to EG_SEND when a committed length is queued, and pops that length. EG_SEND returns to EG_IDLE when the last word is accepted or when a transmit clear occurs.

Top module: `pktq_fifo`

## Requirements
- R1: After reset, status reads 0, transmit vacancy equals the transmit depth (64 words by default), receive occupancy is 0, irq is low and tx_valid is low.
- R2: Transmit data words are not sent before a matching length is written to register 5. After that, each word appears once in order on tx_data. tx_sof marks the first word, tx_eof marks the last, and tx_bytes on the last word is the byte count modulo 4 (4 when that is 0); tx_bytes is 4 on every other word.
- R3: A length write whose byte count is 0, whose word count ceil(len/4) differs from the words pushed since the last commit, or that finds the length queue full sets status bit 25. It discards those uncommitted words, so vacancy returns to its earlier value and nothing is sent.
- R4: A write to the transmit data port (register 4) while vacancy is 0 sets status bit 28 and the word is dropped.
- R5: Status bit 27 is set when the last word of a transmit packet is accepted on the stream.
- R6: Register 7 reads the receive word count. Reading register 9 pops and returns the oldest received byte length, and reading register 8 pops the oldest data word. Status bit 26 is a live flag that is 1 exactly while at least one received length is queued.
- R7: Reading register 8 while receive occupancy is 0 sets status bit 31. Reading register 9 while no length is queued sets status bit 30.
- R8: A stream input word that arrives while the receive data store is full is dropped and sets status bit 29.
- R9: Writing exactly 0xA5 to register 2 clears the transmit path, to register 6 clears the receive path, and to register 10 clears both. Any other value written there changes nothing.
- R10: Two cycles after a key write has taken effect, transmit clear completion shows in status bit 24 and receive clear completion in bit 23.
- R11: irq is high exactly when some status bit is 1 and the same bit of the enable register (register 1) is 1.
- R12: Writing to status (register 0) clears the stored bits 31..27 and 25..23 where the written value has a 1. Writing zeros leaves them unchanged.
- R13: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data and tx_eof hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on the data and length ports) |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request |
| rx_valid | input | 1 | Input stream word valid |
| rx_data | input | 32 | Input stream word |
| rx_last | input | 1 | Last word of the input packet |
| rx_bytes | input | 3 | Valid bytes in the last input word (1..4) |
| tx_valid | output | 1 | Output stream word valid |
| tx_ready | input | 1 | Output stream sink ready |
| tx_data | output | 32 | Output stream word |
| tx_sof | output | 1 | First word of the output packet |
| tx_eof | output | 1 | Last word of the output packet |
| tx_bytes | output | 3 | Valid bytes in the output word (1..4) |

## Verification
The hardest condition to reach is a full store. The transmit overrun and receive drop flags need the full default depth of words held at once. The bench holds tx_ready low and pushes 64 transmit words, then one more. It then commits a 256-byte length and checks that exactly the 64 stored words come out, with the extra word absent. On the receive side it streams a single 65-word packet, so that the final word meets a full store. It then uses the receive key to empty the store again.

// File: rtl/pktq_pkg.sv
package pktq_pkg;

    typedef enum logic [3:0] {
        A_STATUS       = 4'd0,
        A_ENABLE       = 4'd1,
        A_TX_RESET     = 4'd2,
        A_TX_VACANCY   = 4'd3,
        A_TX_DATA      = 4'd4,
        A_TX_LENGTH    = 4'd5,
        A_RX_RESET     = 4'd6,
        A_RX_OCCUPANCY = 4'd7,
        A_RX_DATA      = 4'd8,
        A_RX_LENGTH    = 4'd9,
        A_STREAM_RESET = 4'd10
    } reg_addr_e;

    localparam int B_RX_RD_UNDER = 31;
    localparam int B_RX_RD_OVER  = 30;
    localparam int B_RX_DROP     = 29;
    localparam int B_TX_OVER     = 28;
    localparam int B_TX_DONE     = 27;
    localparam int B_RX_READY    = 26;
    localparam int B_TX_SIZE     = 25;
    localparam int B_TX_RST_DONE = 24;
    localparam int B_RX_RST_DONE = 23;

    localparam logic [31:0] STICKY_MASK = 32'hFB80_0000;
    localparam logic [31:0] RESET_KEY   = 32'h0000_00A5;

    localparam int LEN_W = 11;
    localparam int CNT_W = 9;

    typedef enum logic {EG_IDLE, EG_SEND} eg_state_e;
    typedef enum logic {RS_IDLE, RS_CLEAR} rs_state_e;

endpackage

// File: rtl/pktq_ring.sv
module pktq_ring #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    input  logic             unwind,
    input  logic [CW-1:0]    unwind_n,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            rd_ptr <= rd_ptr + AW'(pop);
            if (unwind) begin
                wr_ptr <= wr_ptr - unwind_n[AW-1:0];
                count  <= count - unwind_n - CW'(pop);
            end else begin
                wr_ptr <= wr_ptr + AW'(push);
                count  <= count + CW'(push) - CW'(pop);
            end
        end
    end

    assign rdata = mem[rd_ptr];

    a_r4_push_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr) |-> (count != CW'(DEPTH)));
    a_r7_pop_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clr) |-> (count != '0));
    a_r3_unwind_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (unwind && !clr) |-> (unwind_n <= count));

endmodule

// File: rtl/pktq_rst_seq.sv
module pktq_rst_seq
    import pktq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_hit,
    output logic clr,
    output logic done
);
    rs_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        clr      = 1'b0;
        done     = 1'b0;
        unique case (state)
            RS_IDLE: begin
                if (key_hit) state_nx = RS_CLEAR;
            end
            RS_CLEAR: begin
                clr      = 1'b1;
                done     = 1'b1;
                state_nx = RS_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/pktq_tx_egress.sv
module pktq_tx_egress
    import pktq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             len_avail,
    input  logic [LEN_W-1:0] len_head,
    input  logic [31:0]      data_head,
    input  logic             out_ready,
    output logic             len_pop,
    output logic             data_pop,
    output logic             out_valid,
    output logic [31:0]      out_data,
    output logic             out_sof,
    output logic             out_eof,
    output logic [2:0]       out_bytes,
    output logic             sent
);
    eg_state_e state, state_nx;

    logic [LEN_W-2:0] words_left;
    logic [2:0]       tail_bytes;
    logic             first;
    logic [LEN_W:0]   len_round;
    logic             last;

    assign len_round = {1'b0, len_head} + (LEN_W+1)'(3);
    assign last      = (words_left == (LEN_W-1)'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= EG_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            words_left <= '0;
            tail_bytes <= 3'd4;
            first      <= 1'b0;
        end else if (len_pop) begin
            words_left <= len_round[LEN_W:2];
            tail_bytes <= (len_head[1:0] == 2'd0) ? 3'd4 : {1'b0, len_head[1:0]};
            first      <= 1'b1;
        end else if (data_pop) begin
            words_left <= words_left - (LEN_W-1)'(1);
            first      <= 1'b0;
        end
    end

    always_comb begin
        state_nx  = state;
        len_pop   = 1'b0;
        data_pop  = 1'b0;
        out_valid = 1'b0;
        sent      = 1'b0;
        unique case (state)
            EG_IDLE: begin
                if (len_avail && !flush) begin
                    len_pop  = 1'b1;
                    state_nx = EG_SEND;
                end
            end
            EG_SEND: begin
                if (flush) begin
                    state_nx = EG_IDLE;
                end else begin
                    out_valid = 1'b1;
                    if (out_ready) begin
                        data_pop = 1'b1;
                        if (last) begin
                            sent     = 1'b1;
                            state_nx = EG_IDLE;
                        end
                    end
                end
            end
        endcase
    end

    assign out_data  = data_head;
    assign out_sof   = out_valid && first;
    assign out_eof   = out_valid && last;
    assign out_bytes = last ? tail_bytes : 3'd4;

    a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n || flush)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eof)));
    a_r2_sof_after_len: assert property (@(posedge clk) disable iff (!rst_n || flush)
        len_pop |=> out_sof);

endmodule

// File: rtl/pktq_fifo.sv
module pktq_fifo
    import pktq_pkg::*;
#(
    parameter int TX_DEPTH  = 64,
    parameter int RX_DEPTH  = 64,
    parameter int LEN_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    input  logic        rx_valid,
    input  logic [31:0] rx_data,
    input  logic        rx_last,
    input  logic [2:0]  rx_bytes,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [31:0] tx_data,
    output logic        tx_sof,
    output logic        tx_eof,
    output logic [2:0]  tx_bytes
);
    localparam int TX_CW = $clog2(TX_DEPTH) + 1;
    localparam int RX_CW = $clog2(RX_DEPTH) + 1;
    localparam int LQ_CW = $clog2(LEN_DEPTH) + 1;
    localparam logic [TX_CW-1:0] TX_FULL_N = TX_CW'(TX_DEPTH);
    localparam logic [RX_CW-1:0] RX_FULL_N = RX_CW'(RX_DEPTH);
    localparam logic [LQ_CW-1:0] LQ_FULL_N = LQ_CW'(LEN_DEPTH);

    reg_addr_e addr;
    assign addr = reg_addr_e'(reg_addr);

    // reset sequencers
    logic tx_key, rx_key, st_key;
    logic tx_clr, rx_clr, tx_rst_done, rx_rst_done;

    assign tx_key = reg_wr && (addr == A_TX_RESET)     && (reg_wdata == RESET_KEY);
    assign rx_key = reg_wr && (addr == A_RX_RESET)     && (reg_wdata == RESET_KEY);
    assign st_key = reg_wr && (addr == A_STREAM_RESET) && (reg_wdata == RESET_KEY);

    pktq_rst_seq u_tx_rst (
        .clk(clk), .rst_n(rst_n), .key_hit(tx_key || st_key),
        .clr(tx_clr), .done(tx_rst_done));
    pktq_rst_seq u_rx_rst (
        .clk(clk), .rst_n(rst_n), .key_hit(rx_key || st_key),
        .clr(rx_clr), .done(rx_rst_done));

    // transmit path
    logic [31:0]      txd_head;
    logic [TX_CW-1:0] txd_count;
    logic [LEN_W-1:0] txl_head;
    logic [LQ_CW-1:0] txl_count;
    logic [TX_CW-1:0] tx_pend;
    logic             txd_full, txl_full;
    logic             tx_wr, tx_push, tx_over;
    logic             len_wr, len_ok, tx_commit, tx_size_err;
    logic [LEN_W:0]   len_round;
    logic             eg_len_pop, eg_data_pop, eg_sent;

    assign txd_full  = (txd_count == TX_FULL_N);
    assign txl_full  = (txl_count == LQ_FULL_N);
    assign tx_wr     = reg_wr && (addr == A_TX_DATA) && !tx_clr;
    assign tx_push   = tx_wr && !txd_full;
    assign tx_over   = tx_wr && txd_full;
    assign len_wr    = reg_wr && (addr == A_TX_LENGTH) && !tx_clr;
    assign len_round = {1'b0, reg_wdata[LEN_W-1:0]} + (LEN_W+1)'(3);
    assign len_ok    = (reg_wdata[LEN_W-1:0] != '0)
                    && (len_round[LEN_W:2] == (LEN_W-1)'(tx_pend))
                    && !txl_full;
    assign tx_commit   = len_wr && len_ok;
    assign tx_size_err = len_wr && !len_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               tx_pend <= '0;
        else if (tx_clr || tx_commit || tx_size_err) tx_pend <= '0;
        else if (tx_push)                         tx_pend <= tx_pend + TX_CW'(1);
    end

    pktq_ring #(.WIDTH(32), .DEPTH(TX_DEPTH)) u_tx_data (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(tx_push), .wdata(reg_wdata), .pop(eg_data_pop),
        .unwind(tx_size_err && (tx_pend != '0)), .unwind_n(tx_pend),
        .rdata(txd_head), .count(txd_count));

    pktq_ring #(.WIDTH(LEN_W), .DEPTH(LEN_DEPTH)) u_tx_len (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(tx_commit), .wdata(reg_wdata[LEN_W-1:0]), .pop(eg_len_pop),
        .unwind(1'b0), .unwind_n('0),
        .rdata(txl_head), .count(txl_count));

    pktq_tx_egress u_egress (
        .clk(clk), .rst_n(rst_n), .flush(tx_clr),
        .len_avail(txl_count != '0), .len_head(txl_head),
        .data_head(txd_head), .out_ready(tx_ready),
        .len_pop(eg_len_pop), .data_pop(eg_data_pop),
        .out_valid(tx_valid), .out_data(tx_data), .out_sof(tx_sof),
        .out_eof(tx_eof), .out_bytes(tx_bytes), .sent(eg_sent));

    // receive path
    logic [31:0]      rxd_head;
    logic [RX_CW-1:0] rxd_count;
    logic [LEN_W-1:0] rxl_head;
    logic [LQ_CW-1:0] rxl_count;
    logic [LEN_W-1:0] rx_acc, rx_len_now;
    logic             rxd_full, rxl_full, rxd_empty, rxl_empty;
    logic             rx_in, rx_push, rx_drop, rxl_push;
    logic             rd_data, rd_len, rxd_pop, rxl_pop;

    assign rxd_full   = (rxd_count == RX_FULL_N);
    assign rxl_full   = (rxl_count == LQ_FULL_N);
    assign rxd_empty  = (rxd_count == '0);
    assign rxl_empty  = (rxl_count == '0);
    assign rx_in      = rx_valid && !rx_clr;
    assign rx_push    = rx_in && !rxd_full;
    assign rxl_push   = rx_in && rx_last && !rxl_full;
    assign rx_drop    = (rx_in && rxd_full) || (rx_in && rx_last && rxl_full);
    assign rx_len_now = rx_acc + (rx_last ? LEN_W'(rx_bytes) : LEN_W'(4));
    assign rd_data    = reg_rd && (addr == A_RX_DATA)   && !rx_clr;
    assign rd_len     = reg_rd && (addr == A_RX_LENGTH) && !rx_clr;
    assign rxd_pop    = rd_data && !rxd_empty;
    assign rxl_pop    = rd_len && !rxl_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rx_acc <= '0;
        else if (rx_clr)  rx_acc <= '0;
        else if (rx_in)   rx_acc <= rx_last ? '0 : rx_len_now;
    end

    pktq_ring #(.WIDTH(32), .DEPTH(RX_DEPTH)) u_rx_data (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(rx_push), .wdata(rx_data), .pop(rxd_pop),
        .unwind(1'b0), .unwind_n('0),
        .rdata(rxd_head), .count(rxd_count));

    pktq_ring #(.WIDTH(LEN_W), .DEPTH(LEN_DEPTH)) u_rx_len (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(rxl_push), .wdata(rx_len_now), .pop(rxl_pop),
        .unwind(1'b0), .unwind_n('0),
        .rdata(rxl_head), .count(rxl_count));

    // status, enable, interrupt
    logic [31:0] status_q, set_bits, clr_bits, status_view, enable_q;

    always_comb begin
        set_bits                = '0;
        set_bits[B_RX_RD_UNDER] = rd_data && rxd_empty;
        set_bits[B_RX_RD_OVER]  = rd_len && rxl_empty;
        set_bits[B_RX_DROP]     = rx_drop;
        set_bits[B_TX_OVER]     = tx_over;
        set_bits[B_TX_DONE]     = eg_sent;
        set_bits[B_TX_SIZE]     = tx_size_err;
        set_bits[B_TX_RST_DONE] = tx_rst_done;
        set_bits[B_RX_RST_DONE] = rx_rst_done;
    end

    assign clr_bits = (reg_wr && (addr == A_STATUS)) ? reg_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= ((status_q & ~clr_bits) | set_bits) & STICKY_MASK;
            if (reg_wr && (addr == A_ENABLE)) enable_q <= reg_wdata;
        end
    end

    always_comb begin
        status_view             = status_q;
        status_view[B_RX_READY] = !rxl_empty;
    end

    assign irq = |(status_view & enable_q);

    always_comb begin
        case (addr)
            A_STATUS:       reg_rdata = status_view;
            A_ENABLE:       reg_rdata = enable_q;
            A_TX_VACANCY:   reg_rdata = 32'(CNT_W'(TX_FULL_N - txd_count));
            A_RX_OCCUPANCY: reg_rdata = 32'(CNT_W'(rxd_count));
            A_RX_DATA:      reg_rdata = rxd_empty ? '0 : rxd_head;
            A_RX_LENGTH:    reg_rdata = rxl_empty ? '0 : 32'(rxl_head);
            default:        reg_rdata = '0;
        endcase
    end

    a_r5_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
        eg_sent |=> status_q[B_TX_DONE]);
    a_r8_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rxd_full && !rx_clr) |=> status_q[B_RX_DROP]);
    a_r10_tx_rst_done: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clr |=> status_q[B_TX_RST_DONE]);
    a_r10_rx_rst_done: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr |=> status_q[B_RX_RST_DONE]);

endmodule

// File: tb/pktq_fifo_tb.sv
module pktq_fifo_tb;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [31:0] rx_data = '0;
    logic [2:0]  rx_bytes = 3'd4;
    logic        tx_valid, tx_sof, tx_eof;
    logic        tx_ready = 1'b1;
    logic [31:0] tx_data;
    logic [2:0]  tx_bytes;

    int n_tests = 0;
    int n_fail  = 0;
    int cap_n   = 0;
    logic [31:0] cap_data  [256];
    logic        cap_sof   [256];
    logic        cap_eof   [256];
    logic [2:0]  cap_bytes [256];

    always #2 clk = ~clk;

    pktq_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_bytes(rx_bytes), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_bytes(tx_bytes));

    always @(negedge clk) begin
        if (tx_valid && tx_ready && cap_n < 256) begin
            cap_data[cap_n]  = tx_data;
            cap_sof[cap_n]   = tx_sof;
            cap_eof[cap_n]   = tx_eof;
            cap_bytes[cap_n] = tx_bytes;
            cap_n = cap_n + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rx_pkt(input int nw, input logic [2:0] lastb, input logic [31:0] base);
        for (int i = 0; i < nw; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = base + 32'(i);
            rx_last = (i == nw - 1); rx_bytes = (i == nw - 1) ? lastb : 3'd4;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic clear_status();
        wr(4'd0, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'd0, v); check("R1 status", v, 32'h0);
        rd(4'd3, v); check("R1 vacancy", v, 32'(DEPTH));
        rd(4'd7, v); check("R1 occupancy", v, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 tx_valid", 32'(tx_valid), 32'h0);
    endtask

    task automatic t_tx_basic();
        logic [31:0] v;
        int c0;
        c0 = cap_n;
        wr(4'd4, 32'hA000_0001); wr(4'd4, 32'hA000_0002); wr(4'd4, 32'hA000_0003);
        idle(3);
        check("R2 held before length", 32'(tx_valid), 32'h0);
        wr(4'd5, 32'd10);
        idle(10);
        check("R2 word count", 32'(cap_n - c0), 32'd3);
        check("R2 word0", cap_data[c0], 32'hA000_0001);
        check("R2 word2", cap_data[c0+2], 32'hA000_0003);
        check("R2 sof first", {cap_sof[c0], cap_sof[c0+1], cap_sof[c0+2]}, 32'b100);
        check("R2 eof last", {cap_eof[c0], cap_eof[c0+1], cap_eof[c0+2]}, 32'b001);
        check("R2 tail bytes", 32'(cap_bytes[c0+2]), 32'd2);
        check("R2 mid bytes", 32'(cap_bytes[c0]), 32'd4);
        rd(4'd0, v); check("R5 tx done bit", 32'(v[27]), 32'd1);
        rd(4'd3, v); check("R2 vacancy restored", v, 32'(DEPTH));
        clear_status();
    endtask

    task automatic t_backpressure();
        logic [31:0] d0;
        int c0;
        c0 = cap_n;
        tx_ready = 1'b0;
        wr(4'd4, 32'hB0B0_0000); wr(4'd4, 32'hB0B0_0001);
        wr(4'd5, 32'd8);
        idle(4);
        check("R13 valid while stalled", 32'(tx_valid), 32'd1);
        check("R13 sof while stalled", 32'(tx_sof), 32'd1);
        d0 = tx_data;
        check("R13 head word", d0, 32'hB0B0_0000);
        idle(3);
        check("R13 data stable", tx_data, d0);
        check("R13 still valid", 32'(tx_valid), 32'd1);
        tx_ready = 1'b1;
        idle(5);
        check("R13 words after release", 32'(cap_n - c0), 32'd2);
        check("R2 full tail bytes", 32'(cap_bytes[c0+1]), 32'd4);
        clear_status();
    endtask

    task automatic t_size_err();
        logic [31:0] v;
        int c0;
        c0 = cap_n;
        wr(4'd4, 32'h1); wr(4'd4, 32'h2);
        wr(4'd5, 32'd13);
        idle(6);
        rd(4'd0, v); check("R3 size error bit", 32'(v[25]), 32'd1);
        rd(4'd3, v); check("R3 words discarded", v, 32'(DEPTH));
        check("R3 nothing sent", 32'(cap_n - c0), 32'd0);
        wr(4'd0, 32'h0);
        rd(4'd0, v); check("R12 zero write keeps", 32'(v[25]), 32'd1);
        wr(4'd0, 32'h0200_0000);
        rd(4'd0, v); check("R12 one clears", 32'(v[25]), 32'd0);
    endtask

    task automatic t_overrun();
        logic [31:0] v;
        int c0;
        c0 = cap_n;
        tx_ready = 1'b0;
        for (int i = 0; i < DEPTH; i++) wr(4'd4, 32'hC000_0000 + 32'(i));
        rd(4'd3, v); check("R4 vacancy zero", v, 32'h0);
        wr(4'd4, 32'hDEAD_BEEF);
        rd(4'd0, v); check("R4 overrun bit", 32'(v[28]), 32'd1);
        wr(4'd5, 32'(DEPTH * 4));
        tx_ready = 1'b1;
        idle(DEPTH + 10);
        check("R4 stored words sent", 32'(cap_n - c0), 32'(DEPTH));
        check("R4 last word not dropped one", cap_data[c0 + DEPTH - 1], 32'hC000_0000 + 32'(DEPTH - 1));
        check("R2 eof on last", 32'(cap_eof[c0 + DEPTH - 1]), 32'd1);
        clear_status();
    endtask

    task automatic t_rx();
        logic [31:0] v;
        rx_pkt(3, 3'd3, 32'hD000_0000);
        rx_pkt(1, 3'd4, 32'hE000_0000);
        rd(4'd7, v); check("R6 occupancy", v, 32'd4);
        rd(4'd0, v); check("R6 ready flag set", 32'(v[26]), 32'd1);
        rd(4'd9, v); check("R6 first length", v, 32'd11);
        rd(4'd8, v); check("R6 word0", v, 32'hD000_0000);
        rd(4'd8, v); rd(4'd8, v); check("R6 word2", v, 32'hD000_0002);
        rd(4'd9, v); check("R6 second length", v, 32'd4);
        rd(4'd8, v); check("R6 second word", v, 32'hE000_0000);
        rd(4'd0, v); check("R6 ready flag clear", 32'(v[26]), 32'd0);
    endtask

    task automatic t_rx_underrun();
        logic [31:0] v;
        clear_status();
        rd(4'd8, v);
        rd(4'd0, v); check("R7 data underrun bit", 32'(v[31]), 32'd1);
        rd(4'd9, v);
        rd(4'd0, v); check("R7 length read error bit", 32'(v[30]), 32'd1);
        clear_status();
    endtask

    task automatic t_rx_drop();
        logic [31:0] v;
        rx_pkt(DEPTH + 1, 3'd4, 32'hF000_0000);
        rd(4'd0, v); check("R8 drop bit", 32'(v[29]), 32'd1);
        rd(4'd7, v); check("R8 occupancy capped", v, 32'(DEPTH));
        wr(4'd6, 32'hA5);
        idle(2);
        rd(4'd7, v); check("R9 rx key empties", v, 32'h0);
        rd(4'd0, v); check("R10 rx done bit", 32'(v[23]), 32'd1);
        check("R9 rx lengths cleared", 32'(v[26]), 32'd0);
        clear_status();
    endtask

    task automatic t_keys();
        logic [31:0] v;
        int c0;
        wr(4'd4, 32'h11); wr(4'd4, 32'h22);
        wr(4'd2, 32'h12);
        idle(3);
        rd(4'd3, v); check("R9 wrong key ignored", v, 32'(DEPTH - 2));
        rd(4'd0, v); check("R9 no done on wrong key", 32'(v[24]), 32'd0);
        wr(4'd2, 32'hA5);
        idle(2);
        rd(4'd3, v); check("R9 tx key empties", v, 32'(DEPTH));
        rd(4'd0, v); check("R10 tx done bit", 32'(v[24]), 32'd1);
        c0 = cap_n;
        wr(4'd4, 32'h33); wr(4'd5, 32'd4);
        idle(6);
        rd(4'd0, v); check("R9 pending count cleared", 32'(v[25]), 32'd0);
        check("R9 send after clear", 32'(cap_n - c0), 32'd1);
        wr(4'd0, 32'h0100_0000);
        rd(4'd0, v); check("R12 done bit cleared", 32'(v[24]), 32'd0);
        wr(4'd10, 32'hA5);
        idle(2);
        rd(4'd0, v); check("R10 stream key both bits", 32'({v[24], v[23]}), 32'b11);
        clear_status();
    endtask

    task automatic t_irq();
        wr(4'd1, 32'h0);
        wr(4'd5, 32'd4);
        idle(1);
        check("R11 masked", 32'(irq), 32'd0);
        wr(4'd1, 32'h0200_0000);
        idle(1);
        check("R11 enabled", 32'(irq), 32'd1);
        clear_status();
        idle(1);
        check("R11 cleared", 32'(irq), 32'd0);
        wr(4'd1, 32'h0400_0000);
        rx_pkt(1, 3'd1, 32'h5);
        idle(1);
        check("R11 live rx flag", 32'(irq), 32'd1);
        wr(4'd6, 32'hA5);
        idle(2);
        check("R11 live flag gone", 32'(irq), 32'd0);
        wr(4'd1, 32'h0);
        clear_status();
    endtask

    bit finished = 1'b0;

    initial begin
        #(4 * 100000);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_tx_basic();
        t_backpressure();
        t_size_err();
        t_overrun();
        t_rx();
        t_rx_underrun();
        t_rx_drop();
        t_keys();
        t_irq();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule